// File: doc/BRIEF.md
# Page Table Word Cache

This block keeps recently used page-directory and page-table words close to a hardware page walker. The walker hands over a 32-bit word address (physical byte address bits 33:2). When the word is held and the cache is enabled, the stored word comes back one cycle later and memory is never touched. Otherwise one read goes out on a valid/ready request channel. The returned word is passed to the walker and, if allowed, written into a direct-mapped line. Memory answers reads in the order they were issued. The walker always accepts responses, and they come back in the order the lookups were accepted.

Software controls the block through three write ports. The configuration word holds the enable bit, a cap on the number of reads in flight, and an index mask. The flush word either drops every line or drops every line inside one memory atom, chosen by physical address. A 2-bit high-address register supplies physical bits 33:32 for that address match. Each table word is 32 bits, and a table holds 1024 of them. The walker forms the addresses; the cache treats them as flat words.

Top module: `ptw_word_cache`

## Requirements
- R1: After reset the cache is disabled and holds no valid line. `rsp_valid_o` and `mem_req_valid_o` are low and `req_ready_o` is high.
- R2: While the enable bit is 0, every lookup issues exactly one memory read and returns the memory word. No line is allocated, so the first lookup after enabling also misses.
- R3: When enabled, a lookup of a held word returns the stored word on `rsp_data_o` without issuing any memory read.
- R4: When enabled, a lookup that misses issues one read at the same word address and returns the memory data. The word is then held.
- R5: A flush write with bit 0 = 0 invalidates every line.
- R6: A flush write with bit 0 = 1 forms the byte address {high register, bits 31:1, 0}. It aligns that address down to the atom size (ATOM_LG = 5, i.e. 32 bytes = 8 words) and invalidates every line whose word falls in that atom. Lines outside the atom stay valid.
- R7: The 2-bit high-address register supplies byte-address bits 33:32 for the address flush. A flush whose low bits match a line but whose high bits do not leaves that line valid.
- R8: Configuration word fields: bit 29 is the enable, bits 27:24 are the read limit, and bits 5:0 are the index mask. With a non-zero limit, the number of memory reads in flight never exceeds it.
- R9: A limit of 0 removes the cap. Reads in flight are then bounded only by the 16-entry order queue.
- R10: A flush that arrives while a read is in flight stops that read's data from being allocated. The word is still returned to the walker.
- R11: Responses come back in the order the lookups were accepted, including a hit queued behind an outstanding miss.
- R12: The line index is word-address bits 5:0 ANDed with the index mask. Two addresses that share a masked index evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Walker lookup valid |
| req_ready_o | output | 1 | Lookup accepted this cycle |
| req_addr_i | input | 32 | Word address (byte bits 33:2) |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_data_o | output | 32 | Table word returned |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_addr_o | output | 32 | Memory read word address |
| mem_rsp_valid_i | input | 1 | Memory read data valid (in order) |
| mem_rsp_data_i | input | 32 | Memory read data |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 32 | Configuration word |
| flush_we_i | input | 1 | Flush word write strobe |
| flush_wdata_i | input | 32 | Flush word: bit 0 type, rest address |
| flush_hi_we_i | input | 1 | High-address register write strobe |
| flush_hi_wdata_i | input | 2 | Physical address bits 33:32 for flush |

## Verification
A stale valid bit or a wrong tag shows up at the ports as a missing or extra memory read on the next lookup of that word. The same fault can return a word from an older memory version in the same response cycle, so the bench changes the memory contents between lookups to tell hits from misses. A wrong read counter or a lost no-allocate mark shows up within one memory latency. It appears either as more reads in flight than the limit allows, or as a later lookup that hits when it should have gone back to memory. A broken order queue shows up as responses that are swapped or shifted against the lookup order.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned WADDR_W    = 32;
  localparam int unsigned PADDR_W    = WADDR_W + 2;
  localparam int unsigned HI_W       = PADDR_W - 32;
  localparam int unsigned CFG_EN_BIT = 29;
  localparam int unsigned CFG_LIM_LSB = 24;
  localparam int unsigned LIM_W      = 4;
  localparam int unsigned MAP_W      = 6;

  typedef struct packed {
    logic               is_hit;
    logic               no_alloc;
    logic [WORD_W-1:0]  data;
    logic [WADDR_W-1:0] addr;
  } ptc_op_t;
endpackage

// File: rtl/ptc_cfg.sv
module ptc_cfg
  import ptc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic             hi_we_i,
  input  logic [HI_W-1:0]  hi_wdata_i,
  output logic             en_o,
  output logic [LIM_W-1:0] lim_o,
  output logic [MAP_W-1:0] map_o,
  output logic [HI_W-1:0]  hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      lim_o <= '0;
      map_o <= '0;
      hi_o  <= '0;
    end else begin
      if (cfg_we_i) begin
        en_o  <= cfg_wdata_i[CFG_EN_BIT];
        lim_o <= cfg_wdata_i[CFG_LIM_LSB +: LIM_W];
        map_o <= cfg_wdata_i[MAP_W-1:0];
      end
      if (hi_we_i) hi_o <= hi_wdata_i;
    end
  end

  logic unused_cfg;
  assign unused_cfg = ^{cfg_wdata_i[31:30], cfg_wdata_i[28], cfg_wdata_i[23:MAP_W]};
endmodule

// File: rtl/ptc_store.sv
module ptc_store
  import ptc_pkg::*;
#(
  parameter int unsigned LINES_LG = 6,
  parameter int unsigned ATOM_LG  = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [WADDR_W-1:0]         look_addr_i,
  input  logic [MAP_W-1:0]           map_i,
  output logic                       hit_o,
  output logic [WORD_W-1:0]          hit_data_o,
  input  logic                       fill_en_i,
  input  logic [WADDR_W-1:0]         fill_addr_i,
  input  logic [WORD_W-1:0]          fill_data_i,
  input  logic                       flush_all_i,
  input  logic                       flush_line_i,
  input  logic [PADDR_W-ATOM_LG-1:0] flush_atom_i
);
  localparam int unsigned LINES   = 1 << LINES_LG;
  localparam int unsigned TAG_LSB = ATOM_LG - 2;

  logic [LINES-1:0]   vld_q;
  logic [WADDR_W-1:0] tag_q  [LINES];
  logic [WORD_W-1:0]  data_q [LINES];
  logic [LINES_LG-1:0] look_idx, fill_idx;

  assign look_idx = look_addr_i[LINES_LG-1:0] & map_i[LINES_LG-1:0];
  assign fill_idx = fill_addr_i[LINES_LG-1:0] & map_i[LINES_LG-1:0];

  assign hit_o      = vld_q[look_idx] && (tag_q[look_idx] == look_addr_i);
  assign hit_data_o = data_q[look_idx];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic in_atom;
    assign in_atom = (tag_q[i][WADDR_W-1:TAG_LSB] == flush_atom_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   vld_q[i] <= 1'b0;
      else if (flush_all_i || (flush_line_i && in_atom)) vld_q[i] <= 1'b0;
      else if (fill_en_i && fill_idx == LINES_LG'(i)) vld_q[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      tag_q[fill_idx]  <= fill_addr_i;
      data_q[fill_idx] <= fill_data_i;
    end
  end
endmodule

// File: rtl/ptc_order_q.sv
module ptc_order_q
  import ptc_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    push_i,
  input  ptc_op_t push_op_i,
  input  logic    pop_i,
  input  logic    mark_all_i,
  output logic    head_vld_o,
  output ptc_op_t head_op_o,
  output logic    full_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  ptc_op_t          q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [PTR_W:0]   cnt_q;

  assign head_vld_o = (cnt_q != '0);
  assign full_o     = (cnt_q == (PTR_W+1)'(DEPTH));
  assign head_op_o  = q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop_i)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + (PTR_W+1)'(push_i) - (PTR_W+1)'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (mark_all_i)
      for (int i = 0; i < DEPTH; i++) q[i].no_alloc <= 1'b1;
    if (push_i) q[wr_q] <= push_op_i;
  end
endmodule

// File: rtl/ptw_word_cache.sv
module ptw_word_cache
  import ptc_pkg::*;
#(
  parameter int unsigned LINES_LG = 6,
  parameter int unsigned ATOM_LG  = 5,
  parameter int unsigned DEPTH    = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_addr_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_data_o,
  output logic        mem_req_valid_o,
  input  logic        mem_req_ready_i,
  output logic [31:0] mem_req_addr_o,
  input  logic        mem_rsp_valid_i,
  input  logic [31:0] mem_rsp_data_i,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        flush_we_i,
  input  logic [31:0] flush_wdata_i,
  input  logic        flush_hi_we_i,
  input  logic [1:0]  flush_hi_wdata_i
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             cfg_en;
  logic [LIM_W-1:0] cfg_lim;
  logic [MAP_W-1:0] cfg_map;
  logic [HI_W-1:0]  cfg_hi;

  ptc_cfg i_cfg (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_wdata_i,
    .hi_we_i (flush_hi_we_i), .hi_wdata_i (flush_hi_wdata_i),
    .en_o (cfg_en), .lim_o (cfg_lim), .map_o (cfg_map), .hi_o (cfg_hi)
  );

  // flush decode: byte address {hi, word[31:1], 0}, atom-aligned
  logic               flush_all, flush_line;
  logic [PADDR_W-1:0] flush_pa;
  assign flush_all  = flush_we_i && !flush_wdata_i[0];
  assign flush_line = flush_we_i &&  flush_wdata_i[0];
  assign flush_pa   = {cfg_hi, flush_wdata_i[31:1], 1'b0};

  logic unused_flush;
  assign unused_flush = ^flush_pa[ATOM_LG-1:0];

  logic        st_hit, fill_en;
  logic [31:0] st_data;
  ptc_op_t     push_op, head_op;
  logic        q_full, head_vld, push, pop;

  ptc_store #(.LINES_LG(LINES_LG), .ATOM_LG(ATOM_LG)) i_store (
    .clk_i, .rst_ni,
    .look_addr_i (req_addr_i), .map_i (cfg_map),
    .hit_o (st_hit), .hit_data_o (st_data),
    .fill_en_i (fill_en), .fill_addr_i (head_op.addr), .fill_data_i (mem_rsp_data_i),
    .flush_all_i (flush_all), .flush_line_i (flush_line),
    .flush_atom_i (flush_pa[PADDR_W-1:ATOM_LG])
  );

  // in-flight read counter and limit
  logic [CNT_W-1:0] rd_cnt_q;
  logic             lim_ok, look_hit, mem_hs;
  assign lim_ok   = (cfg_lim == '0) || (rd_cnt_q < CNT_W'(cfg_lim));
  assign look_hit = cfg_en && st_hit;

  assign mem_req_valid_o = req_valid_i && !look_hit && !q_full && lim_ok;
  assign mem_req_addr_o  = req_addr_i;
  assign mem_hs          = mem_req_valid_o && mem_req_ready_i;
  assign req_ready_o     = !q_full && (look_hit || (lim_ok && mem_req_ready_i));
  assign push            = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_cnt_q <= '0;
    else         rd_cnt_q <= rd_cnt_q + CNT_W'(mem_hs) - CNT_W'(mem_rsp_valid_i);
  end

  always_comb begin
    push_op.is_hit   = look_hit;
    push_op.no_alloc = !cfg_en || flush_we_i;
    push_op.data     = st_data;
    push_op.addr     = req_addr_i;
  end

  ptc_order_q #(.DEPTH(DEPTH)) i_order_q (
    .clk_i, .rst_ni,
    .push_i (push), .push_op_i (push_op),
    .pop_i (pop), .mark_all_i (flush_we_i),
    .head_vld_o (head_vld), .head_op_o (head_op), .full_o (q_full)
  );

  assign rsp_valid_o = head_vld && (head_op.is_hit || mem_rsp_valid_i);
  assign rsp_data_o  = head_op.is_hit ? head_op.data : mem_rsp_data_i;
  assign pop         = rsp_valid_o;
  assign fill_en     = head_vld && !head_op.is_hit && mem_rsp_valid_i &&
                       !head_op.no_alloc && !flush_we_i && cfg_en;
endmodule

// File: rtl/ptw_word_cache_check.sv
module ptw_word_cache_check (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       rsp_valid_o,
  input logic       mem_req_valid_o,
  input logic       mem_req_ready_i,
  input logic       mem_rsp_valid_i,
  input logic       en,
  input logic [3:0] lim
);
  logic [7:0] pend_q, rd_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      rd_q   <= '0;
    end else begin
      pend_q <= pend_q + 8'(req_valid_i && req_ready_o) - 8'(rsp_valid_o);
      rd_q   <= rd_q + 8'(mem_req_valid_o && mem_req_ready_i) - 8'(mem_rsp_valid_i);
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim != 4'd0 && rd_q >= 8'(lim)) |-> !mem_req_valid_o);
  p_rsp_pending_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> pend_q != 8'd0);
  p_bypass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && rsp_valid_o) |-> mem_rsp_valid_i);
  p_read_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> req_valid_i);
endmodule

bind ptw_word_cache ptw_word_cache_check i_ptw_word_cache_check (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .rsp_valid_o     (rsp_valid_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .en              (cfg_en),
  .lim             (cfg_lim)
);

// File: tb/test_ptw_word_cache.sv
module test_ptw_word_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        req_valid = 0, req_ready, rsp_valid, mem_req_valid;
  logic [31:0] req_addr = 0, rsp_data, mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic        cfg_we = 0, flush_we = 0, hi_we = 0;
  logic [31:0] cfg_wdata = 0, flush_wdata = 0;
  logic [1:0]  hi_wdata = 0;

  ptw_word_cache i_ptw_word_cache (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (req_valid), .req_ready_o (req_ready), .req_addr_i (req_addr),
    .rsp_valid_o (rsp_valid), .rsp_data_o (rsp_data),
    .mem_req_valid_o (mem_req_valid), .mem_req_ready_i (1'b1), .mem_req_addr_o (mem_req_addr),
    .mem_rsp_valid_i (mem_rsp_valid), .mem_rsp_data_i (mem_rsp_data),
    .cfg_we_i (cfg_we), .cfg_wdata_i (cfg_wdata),
    .flush_we_i (flush_we), .flush_wdata_i (flush_wdata),
    .flush_hi_we_i (hi_we), .flush_hi_wdata_i (hi_wdata)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, lat = 3, ver = 0;
  int reads = 0, out_now = 0, max_out = 0;
  int rsp_n = 0;
  logic [31:0] rsp_log [256];
  logic [31:0] mq_data [64];
  int          mq_due  [64];
  int mq_hd = 0, mq_tl = 0, mq_cnt = 0;
  bit acc = 0;

  function automatic logic [31:0] mdata(logic [31:0] a, int v);
    return a ^ (32'(v) * 32'h0101_0000) ^ 32'h5A00_00A5;
  endfunction

  // sample point, 2 ns before each rising edge
  always @(negedge clk) begin
    #2;
    if (mem_rsp_valid) begin
      mq_hd = (mq_hd + 1) % 64; mq_cnt--; out_now--;
    end
    if (mem_req_valid) begin
      mq_data[mq_tl] = mdata(mem_req_addr, ver);
      mq_due[mq_tl]  = cyc + lat;
      mq_tl = (mq_tl + 1) % 64; mq_cnt++; reads++; out_now++;
      if (out_now > max_out) max_out = out_now;
    end
    if (rsp_valid) begin rsp_log[rsp_n % 256] = rsp_data; rsp_n++; end
    if (req_valid && req_ready) acc = 1;
    cyc++;
  end

  always @(posedge clk) begin
    #1;
    if (mq_cnt > 0 && mq_due[mq_hd] <= cyc) begin
      mem_rsp_valid = 1; mem_rsp_data = mq_data[mq_hd];
    end else begin
      mem_rsp_valid = 0;
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung act=%0d exp=%0d", cyc, 0);
    finish_run();
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic issue(logic [31:0] a);
    req_valid = 1; req_addr = a; acc = 0;
    do @(negedge clk); while (!acc);
    acc = 0;
  endtask
  task automatic idle(); req_valid = 0; endtask
  task automatic wait_rsp(int n); while (rsp_n < n) @(negedge clk); endtask
  task automatic settle(); while (mq_cnt != 0 || mem_rsp_valid) @(negedge clk); @(negedge clk); endtask

  task automatic lookup(logic [31:0] a, output logic [31:0] d);
    int n = rsp_n;
    issue(a); idle(); wait_rsp(n + 1); d = rsp_log[n % 256];
  endtask
  task automatic cfg_write(logic [31:0] w);
    cfg_we = 1; cfg_wdata = w; @(negedge clk); cfg_we = 0;
  endtask
  task automatic flush(logic [31:0] w);
    flush_we = 1; flush_wdata = w; @(negedge clk); flush_we = 0;
  endtask
  task automatic hi_write(logic [1:0] h);
    hi_we = 1; hi_wdata = h; @(negedge clk); hi_we = 0;
  endtask

  localparam logic [31:0] A = 32'h0000_1000;  // index 0, byte 0x4000
  localparam logic [31:0] B = 32'h0000_2041;  // index 1
  localparam logic [31:0] C = 32'h4000_0010;  // byte addr 0x1_0000_0040
  localparam logic [31:0] EN_CFG = (32'd1 << 29) | (32'd8 << 24) | 32'h3f;

  task automatic t_reset_r1();
    chk("R1 req_ready", 32'(req_ready), 1);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 mem_req_valid", 32'(mem_req_valid), 0);
  endtask

  task automatic t_disabled_r2();
    logic [31:0] d; int r0 = reads;
    lookup(A, d); chk("R2 data", d, mdata(A, ver));
    lookup(A, d); chk("R2 second read", 32'(reads - r0), 2);
    cfg_write(EN_CFG);
    lookup(A, d); chk("R2 no alloc while off", 32'(reads - r0), 3);
  endtask

  task automatic t_hit_miss_r3_r4();
    logic [31:0] d; int r0;
    flush(32'h0); ver++;
    r0 = reads;
    lookup(B, d); chk("R4 miss data", d, mdata(B, ver));
    chk("R4 one read", 32'(reads - r0), 1);
    ver++;
    lookup(B, d); chk("R3 hit data", d, mdata(B, ver - 1));
    chk("R3 no read", 32'(reads - r0), 1);
  endtask

  task automatic t_flush_all_r5();
    logic [31:0] d; int r0 = reads;
    flush(32'h0);
    lookup(B, d); chk("R5 miss after flush", d, mdata(B, ver));
    chk("R5 read count", 32'(reads - r0), 1);
  endtask

  task automatic t_flush_addr_r6();
    logic [31:0] d; int r0;
    flush(32'h0);
    lookup(A, d); lookup(B, d);
    ver++; r0 = reads;
    flush(32'h0000_4015);  // inside A's 32-byte atom, type bit set
    lookup(A, d); chk("R6 aligned line dropped", d, mdata(A, ver));
    lookup(B, d); chk("R6 other line kept", d, mdata(B, ver - 1));
    chk("R6 reads", 32'(reads - r0), 1);
  endtask

  task automatic t_flush_hi_r7();
    logic [31:0] d; int r0;
    lookup(C, d); ver++; r0 = reads;
    hi_write(2'd0); flush(32'h0000_0041);
    lookup(C, d); chk("R7 hi mismatch keeps", d, mdata(C, ver - 1));
    hi_write(2'd1); flush(32'h0000_0041);
    lookup(C, d); chk("R7 hi match drops", d, mdata(C, ver));
    chk("R7 reads", 32'(reads - r0), 1);
  endtask

  task automatic t_limit_r8_r9();
    int n0;
    lat = 20; flush(32'h0);
    cfg_write((32'd1 << 29) | (32'd2 << 24) | 32'h3f);
    max_out = 0; n0 = rsp_n;
    for (int i = 0; i < 5; i++) issue(32'h0000_3000 + 32'(i) * 8);
    idle(); wait_rsp(n0 + 5);
    chk("R8 limit 2", 32'(max_out), 2);
    for (int i = 0; i < 5; i++)
      chk("R11 order under limit", rsp_log[(n0 + i) % 256], mdata(32'h0000_3000 + 32'(i) * 8, ver));
    settle();
    cfg_write((32'd1 << 29) | 32'h3f);
    max_out = 0; n0 = rsp_n;
    for (int i = 0; i < 5; i++) issue(32'h0000_5000 + 32'(i) * 8);
    idle(); wait_rsp(n0 + 5);
    chk("R9 no limit", 32'(max_out), 5);
    settle(); lat = 3;
    cfg_write(EN_CFG);
  endtask

  task automatic t_flush_inflight_r10();
    logic [31:0] d; int n0, r0;
    lat = 10; flush(32'h0); r0 = reads; n0 = rsp_n;
    issue(A); idle();
    repeat (3) @(negedge clk);
    flush(32'h0);
    wait_rsp(n0 + 1); chk("R10 data still returned", rsp_log[n0 % 256], mdata(A, ver));
    settle(); lat = 3;
    lookup(A, d); chk("R10 not allocated", 32'(reads - r0), 2);
    lookup(A, d); chk("R10 normal alloc later", 32'(reads - r0), 2);
  endtask

  task automatic t_order_r11();
    logic [31:0] d; int n0, r0;
    flush(32'h0); lookup(B, d);
    ver++; lat = 10; r0 = reads; n0 = rsp_n;
    issue(C); issue(B); idle();
    wait_rsp(n0 + 2);
    chk("R11 miss first", rsp_log[n0 % 256], mdata(C, ver));
    chk("R11 hit second", rsp_log[(n0 + 1) % 256], mdata(B, ver - 1));
    chk("R11 one read", 32'(reads - r0), 1);
    settle(); lat = 3;
  endtask

  task automatic t_index_map_r12();
    logic [31:0] d; int r0;
    flush(32'h0);
    cfg_write((32'd1 << 29) | (32'd8 << 24));  // mask 0: single line
    lookup(A, d); lookup(B, d);
    ver++; r0 = reads;
    lookup(A, d); chk("R12 evicted by alias", d, mdata(A, ver));
    chk("R12 reads", 32'(reads - r0), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_r1();
    t_disabled_r2();
    t_hit_miss_r3_r4();
    t_flush_all_r5();
    t_flush_addr_r6();
    t_flush_hi_r7();
    t_limit_r8_r9();
    t_flush_inflight_r10();
    t_order_r11();
    t_index_map_r12();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule